// File: doc/BRIEF.md
# Audio Port Interrupt Controller with Frame Match

This block is the interrupt register of an audio serial port. Eight interrupt sources share the upper half of one 32-bit word. Each source owns two adjacent bits: a pending bit that records that the source has fired, and an enable bit just above it that lets that pending bit reach the interrupt line. The lower half of the word is unused.

Seven sources come from event inputs. The eighth comes from inside the block. A frame counter advances on every frame-sync pulse. Software can reload the counter and program a match value. When the counter steps onto the match value, the frame-count source fires. The single level interrupt output is high while any enabled source is pending.

Software uses a simple write strobe with an address and data, and a combinational read path. Software clears pending bits by writing ones to them.

Top module: `aud_irq_ctl`

## Requirements
- R1: After reset, the control word, the frame counter and the match value all read 0, and `irq` is low.
- R2: Source i (0..7) has its pending bit at bit 16+2i and its enable bit at bit 17+2i of the control word at address 0x00. `ext_evt[j]` drives source j for j = 0..6, and the frame-count comparison drives source 7 (bits 31:30).
- R3: A cycle with `ext_evt[j]` high at a clock edge sets pending bit j at that edge, whatever the enable bit holds.
- R4: Writing the control word clears each pending bit written as 1 and leaves each pending bit written as 0 unchanged.
- R5: Writing the control word loads every enable bit with the written value, and reading the word returns the enable bits.
- R6: If an event and a write-1 clear hit the same pending bit in the same cycle, the bit stays set.
- R7: `irq` is high exactly when at least one source has both its enable bit and its pending bit set.
- R8: The frame counter at address 0x40 increments by one on each cycle where `frame_sync` is high. A write to 0x40 reloads the counter, and that write takes priority over a `frame_sync` in the same cycle.
- R9: The frame counter wraps from 0xFFFFFFFF to 0.
- R10: The match value at address 0x50 can be read and written. When a `frame_sync` increment makes the counter equal to the match value, pending bit 30 is set. A reload write that makes the counter equal to the match value does not set it.
- R11: Bits 15:0 of the control word read 0. Any address other than 0x00, 0x40 and 0x50 reads 0, and writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ext_evt | input | 7 | Event inputs for sources 0..6 |
| frame_sync | input | 1 | One pulse per audio frame |
| irq | output | 1 | Level interrupt output |

## Verification
A wrong pending or enable flop shows up on the very next read of the control word, and on `irq` in the cycle after the faulty edge. The tests probe the pair layout one source at a time, so a swapped bit or a wrong clear polarity appears at the position that is off.

A counter fault surfaces on the next read of 0x40. The most telling cases are a lost increment, a missed wrap, and a reload that fails to override a frame pulse. A faulty match compare shows up as bit 30 being set one frame early, one frame late, or on a reload. The tests look at both the frame before and the frame that hits the match.

// File: rtl/aud_irq_ctl.sv
module aud_irq_ctl #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [6:0]        ext_evt,
  input  logic              frame_sync,
  output logic              irq
);
  localparam int NSRC = 8;
  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'('h50);

  logic [NSRC-1:0]  en_q, pend_q, set_vec;
  logic [CNT_W-1:0] cnt_q, match_q, cnt_inc;
  logic [31:0]      ctl_word;
  logic             ctl_wr, cnt_wr, match_wr, frame_hit;

  assign ctl_wr    = wr_en && (addr == A_CTL);
  assign cnt_wr    = wr_en && (addr == A_CNT);
  assign match_wr  = wr_en && (addr == A_MATCH);
  assign cnt_inc   = cnt_q + 1'b1;
  assign frame_hit = frame_sync && !cnt_wr && (cnt_inc == match_q);
  assign set_vec   = {frame_hit, ext_evt};

  assign ctl_word[15:0] = '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (ctl_wr) en_q[i] <= wdata[17+2*i];
        pend_q[i] <= set_vec[i] | (pend_q[i] & ~(ctl_wr & wdata[16+2*i]));
      end
    end
    assign ctl_word[16+2*i] = pend_q[i];
    assign ctl_word[17+2*i] = en_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= '0;
    end else begin
      if (cnt_wr)          cnt_q <= wdata[CNT_W-1:0];
      else if (frame_sync) cnt_q <= cnt_inc;
      if (match_wr)        match_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = ctl_word;
      A_CNT:   rdata = 32'(cnt_q);
      A_MATCH: rdata = 32'(match_q);
      default: rdata = '0;
    endcase
  end

  assign irq = |(en_q & pend_q);
endmodule

// File: rtl/aud_irq_ctl_chk.sv
module aud_irq_ctl_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [6:0]        ext_evt,
  input logic              frame_sync,
  input logic              irq,
  input logic [7:0]        en_q,
  input logic [7:0]        pend_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  match_q
);
  logic ctl_wr, cnt_wr, other_wr;
  assign ctl_wr   = wr_en && (addr == ADDR_W'('h00));
  assign cnt_wr   = wr_en && (addr == ADDR_W'('h40));
  assign other_wr = wr_en && !ctl_wr && !cnt_wr && (addr != ADDR_W'('h50));

  for (genvar j = 0; j < 7; j++) begin : g_chk
    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ext_evt[j] |=> pend_q[j]);
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && wdata[16+2*j] && !ext_evt[j] |=> !pend_q[j]);
  end

  a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> en_q == {$past(wdata[31]), $past(wdata[29]), $past(wdata[27]), $past(wdata[25]),
                        $past(wdata[23]), $past(wdata[21]), $past(wdata[19]), $past(wdata[17])});
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 8'h00) |-> !irq);
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && !cnt_wr |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync && !cnt_wr |=> $stable(cnt_q));
  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> $stable(match_q) && $stable(en_q));
endmodule

bind aud_irq_ctl aud_irq_ctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ext_evt(ext_evt), .frame_sync(frame_sync), .irq(irq),
  .en_q(en_q), .pend_q(pend_q), .cnt_q(cnt_q), .match_q(match_q)
);

// File: tb/aud_irq_ctl_tb.sv
`timescale 1ns/1ps
module aud_irq_ctl_tb_top;
  logic        clk = 0, rst_n = 0, wr_en = 0, frame_sync = 0, irq;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [6:0]  ext_evt = 0;
  int applied = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aud_irq_ctl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_evt(ext_evt), .frame_sync(frame_sync), .irq(irq));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    applied++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic sync = 0, logic [6:0] ev = 0);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; frame_sync = sync; ext_evt = ev;
    @(negedge clk); wr_en = 0; frame_sync = 0; ext_evt = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_evt(logic [6:0] m);
    @(negedge clk); ext_evt = m; @(negedge clk); ext_evt = 0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); frame_sync = 1; @(negedge clk); frame_sync = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctl", d, 0);
    rd(8'h40, d); chk("R1 cnt", d, 0);
    rd(8'h50, d); chk("R1 match", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_events();
    logic [31:0] d, acc = 0;
    for (int j = 0; j < 7; j++) begin
      pulse_evt(7'(1 << j));
      acc |= 32'(1) << (16 + 2*j);
      rd(8'h00, d); chk("R2 R3 pending position", d, acc);
      chk("R3 irq stays low with enables off", {31'b0, irq}, 0);
    end
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h00, (32'(1) << 16) | (32'(1) << 20));
    rd(8'h00, d); chk("R4 partial clear", d, 32'h1554_0000 & ~32'h0011_0000);
    wr(8'h00, 32'h5555_0000);
    rd(8'h00, d); chk("R4 full clear", d, 0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(8'h00, 32'hAAAA_0000);
    rd(8'h00, d); chk("R5 enables read back", d, 32'hAAAA_0000);
    chk("R7 no pending no irq", {31'b0, irq}, 0);
    pulse_evt(7'b000_0100);
    #1 chk("R7 enabled pending irq", {31'b0, irq}, 1);
    rd(8'h00, d); chk("R5 enables kept by event", d, 32'hAAAA_0000 | (32'(1) << 20));
    wr(8'h00, 32'(1) << 23);
    rd(8'h00, d); chk("R5 enable reload", d, (32'(1) << 23) | (32'(1) << 20));
    chk("R7 pending not enabled", {31'b0, irq}, 0);
    wr(8'h00, 32'(1) << 21);
    chk("R7 re-enabled", {31'b0, irq}, 1);
    wr(8'h00, 32'(1) << 20);
    rd(8'h00, d); chk("R4 clear keeps nothing", d, 0);
    chk("R7 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse_evt(7'b000_0010);
    wr(8'h00, 32'(1) << 18, 0, 7'b000_0010);
    rd(8'h00, d); chk("R6 set beats clear", d, 32'(1) << 18);
    wr(8'h00, 32'(1) << 18);
    rd(8'h00, d); chk("R6 later clear", d, 0);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    wr(8'h50, 32'h0000_1234);
    rd(8'h50, d); chk("R10 match readback", d, 32'h1234);
    for (int k = 0; k < 3; k++) pulse_sync();
    rd(8'h40, d); chk("R8 three frames", d, 3);
    wr(8'h40, 32'h10);
    rd(8'h40, d); chk("R8 reload", d, 32'h10);
    wr(8'h40, 32'h100, 1);
    rd(8'h40, d); chk("R8 reload beats frame pulse", d, 32'h100);
    wr(8'h40, 32'hFFFF_FFFE);
    pulse_sync();
    rd(8'h40, d); chk("R9 top value", d, 32'hFFFF_FFFF);
    pulse_sync();
    rd(8'h40, d); chk("R9 wrap to zero", d, 0);
    rd(8'h00, d); chk("R10 no spurious hit", d, 0);
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(8'h40, 32'h20);
    wr(8'h50, 32'h22);
    pulse_sync();
    rd(8'h00, d); chk("R10 one frame early", d, 0);
    pulse_sync();
    rd(8'h00, d); chk("R10 hit sets bit 30", d, 32'h4000_0000);
    wr(8'h00, 32'h8000_0000);
    chk("R7 frame source irq", {31'b0, irq}, 1);
    wr(8'h00, 32'h4000_0000);
    wr(8'h40, 32'h22);
    rd(8'h00, d); chk("R10 reload to match no hit", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00, d); chk("R11 low half zero", d, 0);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R11 unmapped read", d, 0);
    rd(8'h30, d); chk("R11 other unmapped read", d, 0);
    rd(8'h50, d); chk("R11 match untouched", d, 32'h22);
    rd(8'h40, d); chk("R11 counter untouched", d, 32'h22);
    rd(8'h00, d); chk("R11 control untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_events();
    t_w1c();
    t_enables();
    t_set_wins();
    t_counter();
    t_match();
    t_unmapped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule